// File: doc/BRIEF.md
# Smart-Card Half-Duplex UART with Parity-Error Signalling

This block is a half-duplex asynchronous serial transceiver for a smart-card link. Transmit and receive share one open-drain wire. The block either pulls that wire low or leaves it released, and an external pull-up supplies the high level. The transmitter therefore sees its own waveform on the receive input. Characters carry eight data bits and a parity bit. When the receiver finds wrong parity, it holds the wire low for the whole stop-bit slot, so the far end sees the error on its own line.

A host programs the block through a small register port. Writes are strobed. Reads are combinational on the read address. An 8-bit divider value `n` sets the bit time. The transmit buffer feeds a shift register. The receive shift register feeds a buffer. Status flags and two sticky interrupt requests report progress. The transmit request can be tied either to the buffer emptying or to the shift register completing its stop bit.

Register map:
- Address 0 is control:
  - bit 0 enables transmit.
  - bit 1 enables receive.
  - bit 2 selects odd parity.
  - bit 3 selects the transmit interrupt cause.
- Address 1 holds `n`.
- Address 2 is the transmit buffer on write and the receive buffer on read.
- Address 3 is status:
  - bit 0: transmit buffer empty.
  - bit 1: transmit register empty.
  - bit 2: receive complete.
  - bit 3: parity error.
  - bit 4: transmit interrupt.
  - bit 5: receive interrupt.
  - Writing 1 to bit 4 or bit 5 clears that request.

Top module: `sc_uart`

## Requirements
- R1: Every transmitted bit lasts exactly 16*(n+1) clock cycles, where n is the value at address 1.
- R2: A transmitted frame is a low start bit, data bits D0 first through D7, a parity bit, then a high stop bit; the line is driven low only for 0 bits.
- R3: The parity bit equals the XOR of the eight data bits when control bit 2 is 0 (even), and its inverse when control bit 2 is 1 (odd).
- R4: Writing address 2 clears status bit 0. The start bit does not begin at the write; it begins at the next bit boundary of the free-running divider, at most 16*(n+1) cycles later. Status bit 0 returns to 1 when the buffer moves into the shift register.
- R5: Status bit 1 is 0 from the start bit until the stop bit ends, and 1 otherwise; while it is 1 the transmitter does not drive the line.
- R6: With control bit 3 = 0, the transmit interrupt sets when the buffer moves into the shift register. With bit 3 = 1, it sets only when the stop bit has been fully sent.
- R7: Each interrupt request stays set until its acknowledge input pulses or a 1 is written to its status bit (4 or 5) at address 3.
- R8: The receiver samples each bit in the middle of its bit time. At the end of a frame it stores the data at address 2 and sets status bit 2 and the receive interrupt. Reading address 2 with the read strobe clears status bit 2.
- R9: If received parity is wrong under the selected sense, the receiver drives the line low for the stop-bit slot and status bit 3 reads 1 for that character; with correct parity the line stays released and bit 3 reads 0.
- R10: A low pulse shorter than half a bit time is not taken as a start bit: no character is completed, and the receiver still accepts a following valid frame.
- R11: Clearing control bit 0 mid-frame releases the line and sets status bit 1 within two cycles. With control bit 1 at 0, incoming frames leave status bits 2 and 5 at 0.
- R12: With both directions enabled, a transmitted character is received back from the shared line into the receive buffer with status bit 3 at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also the divider count clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | DATA_W | Register write data |
| rd_en | input | 1 | Register read strobe (side effect on address 2) |
| rd_addr | input | 2 | Register read address |
| rd_data | output | DATA_W | Register read data, combinational on rd_addr |
| tx_irq_ack | input | 1 | Acknowledge pulse for the transmit request |
| rx_irq_ack | input | 1 | Acknowledge pulse for the receive request |
| line_in | input | 1 | Level of the shared wire |
| line_oe | output | 1 | 1 pulls the shared wire low, 0 releases it |
| tx_irq | output | 1 | Transmit interrupt request |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
The bench measures bit edges at the exact cycle where a bit should end. A divider off by one count, or a start bit launched straight from the write instead of at the divider boundary, shows up as a wrong line level one cycle early or late. It drives frames with deliberately wrong parity and checks the line in the middle of the stop slot. A receiver that only flags the error without driving the wire, or that inverts the parity sense, leaves the line high or flags good characters. It also checks three further cases:
- Interrupt timing under both cause settings: a design that ignores the select bit raises the request one frame too early.
- A short glitch, which a receiver without start confirmation would turn into a false character.
- A mid-frame disable, which a transmitter that merely pauses would leave holding the wire low.

// File: rtl/sc_uart_pkg.sv
package sc_uart_pkg;

  typedef enum logic [1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_DIV  = 2'd1,
    ADDR_DATA = 2'd2,
    ADDR_STAT = 2'd3
  } reg_addr_e;

  // control register, bit 3 down to bit 0
  typedef struct packed {
    logic irq_on_shift_done;
    logic odd_parity;
    logic rx_on;
    logic tx_on;
  } ctrl_t;

  localparam int STAT_CLR_TX_BIT = 4;
  localparam int STAT_CLR_RX_BIT = 5;

endpackage

// File: rtl/sc_uart_baud.sv
module sc_uart_baud #(
  parameter int DIV_W = 8,
  parameter int OVS   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  input  logic             restart,
  output logic             tick,
  output logic             bit_tick
);
  localparam int OVS_W = $clog2(OVS);

  logic [DIV_W-1:0] pre_q, pre_d;
  logic [OVS_W-1:0] ph_q, ph_d;

  always_comb begin
    tick     = (pre_q == div);
    bit_tick = tick && (ph_q == OVS_W'(OVS - 1));
    pre_d    = pre_q + 1'b1;
    ph_d     = ph_q;
    if (tick) begin
      pre_d = '0;
      ph_d  = (ph_q == OVS_W'(OVS - 1)) ? '0 : ph_q + 1'b1;
    end
    if (restart) begin
      pre_d = '0;
      ph_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      ph_q  <= '0;
    end else begin
      pre_q <= pre_d;
      ph_q  <= ph_d;
    end
  end
endmodule

// File: rtl/sc_uart_tx.sv
module sc_uart_tx #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              odd,
  input  logic              bit_tick,
  input  logic              buf_wr,
  input  logic [DATA_W-1:0] buf_data,
  output logic              buf_empty,
  output logic              reg_empty,
  output logic              line_low,
  output logic              load_pulse,
  output logic              done_pulse
);
  localparam int FRAME = DATA_W + 3;
  localparam int IDX_W = $clog2(FRAME);

  logic              busy_q, busy_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [FRAME-1:0]  shf_q, shf_d;
  logic [DATA_W-1:0] buf_q, buf_d;
  logic              full_q, full_d;
  logic              last_bit;

  always_comb begin
    last_bit   = busy_q && (idx_q == IDX_W'(FRAME - 1));
    load_pulse = en && full_q && bit_tick && (!busy_q || last_bit);
    done_pulse = en && bit_tick && last_bit;
    busy_d     = busy_q;
    idx_d      = idx_q;
    shf_d      = shf_q;
    if (!en) begin
      busy_d = 1'b0;
      idx_d  = '0;
    end else if (load_pulse) begin
      busy_d = 1'b1;
      idx_d  = '0;
      shf_d  = {1'b1, (^buf_q) ^ odd, buf_q, 1'b0};
    end else if (done_pulse) begin
      busy_d = 1'b0;
      idx_d  = '0;
    end else if (busy_q && bit_tick) begin
      idx_d = idx_q + 1'b1;
      shf_d = shf_q >> 1;
    end
    full_d = buf_wr ? 1'b1 : (load_pulse ? 1'b0 : full_q);
    buf_d  = buf_wr ? buf_data : buf_q;
  end

  assign line_low  = busy_q && !shf_q[0];
  assign buf_empty = !full_q;
  assign reg_empty = !busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      shf_q  <= '1;
      buf_q  <= '0;
      full_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      idx_q  <= idx_d;
      shf_q  <= shf_d;
      buf_q  <= buf_d;
      full_q <= full_d;
    end
  end
endmodule

// File: rtl/sc_uart_rx.sv
module sc_uart_rx #(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              odd,
  input  logic              tick,
  input  logic              line_in,
  input  logic              rd_clr,
  output logic [DATA_W-1:0] rbuf,
  output logic              done,
  output logic              perr,
  output logic              line_low,
  output logic              fin_pulse
);
  localparam int FRAME = DATA_W + 3;
  localparam int IDX_W = $clog2(FRAME);
  localparam int OVS_W = $clog2(OVS);
  localparam logic [OVS_W-1:0] MID = OVS_W'(OVS / 2 - 1);

  logic              act_q, act_d;
  logic [OVS_W-1:0]  ph_q, ph_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic              bad_q, bad_d;
  logic [DATA_W-1:0] rbuf_q, rbuf_d;
  logic              done_q, done_d;
  logic              perr_q, perr_d;
  logic              samp, bit_end;

  always_comb begin
    samp      = act_q && tick && (ph_q == MID);
    bit_end   = act_q && tick && (ph_q == OVS_W'(OVS - 1));
    fin_pulse = 1'b0;
    act_d = act_q;
    ph_d  = ph_q;
    idx_d = idx_q;
    sh_d  = sh_q;
    bad_d = bad_q;
    if (!en) begin
      act_d = 1'b0;
    end else if (!act_q) begin
      if (tick && !line_in) begin
        act_d = 1'b1;
        ph_d  = '0;
        idx_d = '0;
        bad_d = 1'b0;
      end
    end else if (tick) begin
      ph_d = ph_q + 1'b1;
      if (samp) begin
        if (idx_q == '0) begin
          if (line_in) act_d = 1'b0;
        end else if (idx_q <= IDX_W'(DATA_W)) begin
          sh_d = {line_in, sh_q[DATA_W-1:1]};
        end else if (idx_q == IDX_W'(DATA_W + 1)) begin
          bad_d = line_in ^ (^sh_q) ^ odd;
        end
      end
      if (bit_end) begin
        if (idx_q == IDX_W'(FRAME - 1)) begin
          act_d     = 1'b0;
          fin_pulse = 1'b1;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
    end
    rbuf_d = rbuf_q;
    perr_d = perr_q;
    done_d = rd_clr ? 1'b0 : done_q;
    if (fin_pulse) begin
      rbuf_d = sh_q;
      perr_d = bad_q;
      done_d = 1'b1;
    end
  end

  assign line_low = act_q && bad_q && (idx_q == IDX_W'(FRAME - 1));
  assign rbuf     = rbuf_q;
  assign done     = done_q;
  assign perr     = perr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      ph_q   <= '0;
      idx_q  <= '0;
      sh_q   <= '0;
      bad_q  <= 1'b0;
      rbuf_q <= '0;
      done_q <= 1'b0;
      perr_q <= 1'b0;
    end else begin
      act_q  <= act_d;
      ph_q   <= ph_d;
      idx_q  <= idx_d;
      sh_q   <= sh_d;
      bad_q  <= bad_d;
      rbuf_q <= rbuf_d;
      done_q <= done_d;
      perr_q <= perr_d;
    end
  end
endmodule

// File: rtl/sc_uart.sv
module sc_uart #(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [1:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              tx_irq_ack,
  input  logic              rx_irq_ack,
  input  logic              line_in,
  output logic              line_oe,
  output logic              tx_irq,
  output logic              rx_irq
);
  import sc_uart_pkg::*;

  logic             rst_s0, rst_i;
  ctrl_t            ctrl_q, ctrl_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic             txirq_q, txirq_d, rxirq_q, rxirq_d;
  logic [1:0]       lsync_q;
  logic             wr_ctrl, wr_div, wr_buf, wr_stat, rd_clr;
  logic             tick, bit_tick;
  logic             txbuf_empty, txreg_empty, tx_low, tx_load, tx_done;
  logic [DATA_W-1:0] rx_data;
  logic             rx_done, rx_perr, rx_low, rx_fin;
  logic             tx_ev;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s0 <= 1'b0;
      rst_i  <= 1'b0;
    end else begin
      rst_s0 <= 1'b1;
      rst_i  <= rst_s0;
    end
  end

  always_comb begin
    wr_ctrl = wr_en && (wr_addr == ADDR_CTRL);
    wr_div  = wr_en && (wr_addr == ADDR_DIV);
    wr_buf  = wr_en && (wr_addr == ADDR_DATA);
    wr_stat = wr_en && (wr_addr == ADDR_STAT);
    rd_clr  = rd_en && (rd_addr == ADDR_DATA);
    ctrl_d  = wr_ctrl ? ctrl_t'(wr_data[3:0]) : ctrl_q;
    div_d   = wr_div ? wr_data[DIV_W-1:0] : div_q;
    tx_ev   = ctrl_q.irq_on_shift_done ? tx_done : tx_load;
    txirq_d = txirq_q;
    if (tx_irq_ack || (wr_stat && wr_data[STAT_CLR_TX_BIT])) txirq_d = 1'b0;
    if (tx_ev) txirq_d = 1'b1;
    rxirq_d = rxirq_q;
    if (rx_irq_ack || (wr_stat && wr_data[STAT_CLR_RX_BIT])) rxirq_d = 1'b0;
    if (rx_fin) rxirq_d = 1'b1;
  end

  always_comb begin
    case (rd_addr)
      ADDR_CTRL: rd_data = DATA_W'(ctrl_q);
      ADDR_DIV:  rd_data = DATA_W'(div_q);
      ADDR_DATA: rd_data = rx_data;
      default:   rd_data = DATA_W'({rxirq_q, txirq_q, rx_perr, rx_done,
                                    txreg_empty, txbuf_empty});
    endcase
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      ctrl_q  <= '0;
      div_q   <= '0;
      txirq_q <= 1'b0;
      rxirq_q <= 1'b0;
      lsync_q <= 2'b11;
    end else begin
      ctrl_q  <= ctrl_d;
      div_q   <= div_d;
      txirq_q <= txirq_d;
      rxirq_q <= rxirq_d;
      lsync_q <= {lsync_q[0], line_in};
    end
  end

  sc_uart_baud #(.DIV_W(DIV_W), .OVS(OVS)) u_baud (
    .clk(clk), .rst_n(rst_i), .div(div_q), .restart(wr_div),
    .tick(tick), .bit_tick(bit_tick)
  );

  sc_uart_tx #(.DATA_W(DATA_W)) u_tx (
    .clk(clk), .rst_n(rst_i), .en(ctrl_q.tx_on), .odd(ctrl_q.odd_parity),
    .bit_tick(bit_tick), .buf_wr(wr_buf), .buf_data(wr_data),
    .buf_empty(txbuf_empty), .reg_empty(txreg_empty), .line_low(tx_low),
    .load_pulse(tx_load), .done_pulse(tx_done)
  );

  sc_uart_rx #(.DATA_W(DATA_W), .OVS(OVS)) u_rx (
    .clk(clk), .rst_n(rst_i), .en(ctrl_q.rx_on), .odd(ctrl_q.odd_parity),
    .tick(tick), .line_in(lsync_q[1]), .rd_clr(rd_clr),
    .rbuf(rx_data), .done(rx_done), .perr(rx_perr),
    .line_low(rx_low), .fin_pulse(rx_fin)
  );

  assign line_oe = tx_low | rx_low;
  assign tx_irq  = txirq_q;
  assign rx_irq  = rxirq_q;
endmodule

// File: rtl/sc_uart_chk.sv
module sc_uart_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [1:0] wr_addr,
  input logic       wr_clr_tx,
  input logic       rd_en,
  input logic [1:0] rd_addr,
  input logic       tx_irq,
  input logic       tx_irq_ack,
  input logic       txbuf_empty,
  input logic       txreg_empty,
  input logic       tx_low,
  input logic       rx_low,
  input logic       tx_en,
  input logic       rx_en,
  input logic       rx_done,
  input logic       rx_fin
);
  AST_IDLE_TX_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    txreg_empty |-> !tx_low); // R5

  AST_WRITE_FILLS_BUF: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd2) |=> !txbuf_empty); // R4

  AST_TXIRQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_irq && !tx_irq_ack && !(wr_en && wr_addr == 2'd3 && wr_clr_tx)) |=> tx_irq); // R7

  AST_RXDONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == 2'd2 && !rx_fin) |=> !rx_done); // R8

  AST_RX_DRIVE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    rx_low |-> (rx_en || $past(rx_en))); // R9

  AST_TX_OFF_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en && $past(!tx_en)) |-> !tx_low); // R11
endmodule

bind sc_uart sc_uart_chk u_chk (
  .clk(clk), .rst_n(rst_i), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_clr_tx(wr_data[4]), .rd_en(rd_en), .rd_addr(rd_addr),
  .tx_irq(tx_irq), .tx_irq_ack(tx_irq_ack), .txbuf_empty(txbuf_empty),
  .txreg_empty(txreg_empty), .tx_low(tx_low), .rx_low(rx_low),
  .tx_en(ctrl_q.tx_on), .rx_en(ctrl_q.rx_on), .rx_done(rx_done), .rx_fin(rx_fin)
);

// File: tb/tb_sc_uart.sv
module tb_sc_uart;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       rd_en = 1'b0;
  logic [1:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       tx_irq_ack = 1'b0;
  logic       rx_irq_ack = 1'b0;
  logic       ext_low = 1'b0;
  logic       line_oe, tx_irq, rx_irq;
  logic       line;
  int         total = 0;
  int         bad = 0;
  int         bitc = 32;

  assign line = !(line_oe || ext_low);   // pull-up on the shared wire

  always #4 clk = ~clk;

  sc_uart dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .tx_irq_ack(tx_irq_ack), .rx_irq_ack(rx_irq_ack),
    .line_in(line), .line_oe(line_oe), .tx_irq(tx_irq), .rx_irq(rx_irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    #1 v = rd_data;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] v);
    rd_addr = a;
    #1 v = rd_data;
  endtask

  task automatic set_div(input int n);
    reg_wr(2'd1, 8'(n));
    bitc = 16 * (n + 1);
  endtask

  task automatic wait_fall(output int lat);
    lat = 0;
    while (line !== 1'b0 && lat < 2000) begin
      @(negedge clk);
      lat++;
    end
  endtask

  function automatic logic par_of(input logic [7:0] d, input logic odd);
    return odd ? ~^d : ^d;
  endfunction

  task automatic t_reset();
    logic [7:0] s;
    peek(2'd3, s);
    chk(s == 8'h03, "R4/R5 reset status", s, 8'h03);
    chk(line == 1'b1, "R5 reset line released", line, 1);
  endtask

  task automatic t_tx(input logic [7:0] d, input logic odd, input logic sel, input int n);
    logic [7:0] s;
    logic [10:0] fr;
    int lat;
    fr = {1'b1, par_of(d, odd), d, 1'b0};
    set_div(n);
    reg_wr(2'd0, {4'b0, sel, odd, 1'b0, 1'b1});
    reg_wr(2'd3, 8'h30);
    reg_wr(2'd2, d);
    peek(2'd3, s);
    chk(s[0] == 1'b0, "R4 write clears buffer empty", s[0], 0);
    chk(line == 1'b1, "R4 no start at write", line, 1);
    wait_fall(lat);
    chk(lat <= bitc + 2, "R4 start at next divider boundary", lat, bitc);
    peek(2'd3, s);
    chk(s[0] == 1'b1, "R4 buffer empty after transfer", s[0], 1);
    chk(s[1] == 1'b0, "R5 register busy at start", s[1], 0);
    chk(tx_irq == !sel, "R6 irq at transfer", tx_irq, !sel);
    repeat (bitc - 1) @(negedge clk);
    chk(line == 1'b0, "R1 start bit last cycle", line, 0);
    @(negedge clk);
    chk(line == fr[1], "R1 first data bit edge", line, fr[1]);
    repeat (bitc / 2) @(negedge clk);
    for (int i = 1; i < 11; i++) begin
      chk(line == fr[i], (i == 9) ? "R3 parity bit" : "R2 frame bit", line, fr[i]);
      peek(2'd3, s);
      chk(s[1] == 1'b0, "R5 register busy in frame", s[1], 0);
      if (i < 10) repeat (bitc) @(negedge clk);
    end
    chk(tx_irq == !sel, "R6 irq before stop ends", tx_irq, !sel);
    repeat (bitc / 2 + 2) @(negedge clk);
    peek(2'd3, s);
    chk(s[1] == 1'b1, "R5 register empty after stop", s[1], 1);
    chk(tx_irq == 1'b1, "R6/R7 irq after frame", tx_irq, 1);
    reg_wr(2'd0, 8'h00);
  endtask

  task automatic t_irq_clear();
    logic [7:0] s;
    repeat (100) @(negedge clk);
    chk(tx_irq == 1'b1, "R7 irq held", tx_irq, 1);
    tx_irq_ack = 1'b1;
    @(negedge clk);
    tx_irq_ack = 1'b0;
    chk(tx_irq == 1'b0, "R7 ack clears irq", tx_irq, 0);
  endtask

  task automatic send_frame(input logic [7:0] d, input logic odd, input logic flip,
                            input logic expect_drive);
    logic [10:0] fr;
    fr = {1'b1, par_of(d, odd) ^ flip, d, 1'b0};
    for (int i = 0; i < 10; i++) begin
      ext_low = !fr[i];
      repeat (bitc) @(negedge clk);
    end
    ext_low = 1'b0;
    repeat (bitc / 2) @(negedge clk);
    chk(line == !expect_drive, "R9 stop slot level", line, !expect_drive);
    repeat (bitc / 2 + 2 * bitc) @(negedge clk);
  endtask

  task automatic t_rx(input logic [7:0] d, input logic odd, input logic flip);
    logic [7:0] s, v;
    set_div(1);
    reg_wr(2'd0, {5'b0, odd, 2'b10});
    send_frame(d, odd, flip, flip);
    peek(2'd3, s);
    chk(s[2] == 1'b1, "R8 receive complete", s[2], 1);
    chk(s[3] == flip, "R9 parity error flag", s[3], flip);
    chk(rx_irq == 1'b1, "R8 receive irq", rx_irq, 1);
    reg_rd(2'd2, v);
    chk(v == d, "R8 received data", v, d);
    peek(2'd3, s);
    chk(s[2] == 1'b0, "R8 read clears complete", s[2], 0);
    reg_wr(2'd3, 8'h20);
    peek(2'd3, s);
    chk(s[5] == 1'b0, "R7 status write clears rx irq", s[5], 0);
  endtask

  task automatic t_glitch();
    logic [7:0] s, v;
    set_div(1);
    reg_wr(2'd0, 8'h02);
    ext_low = 1'b1;
    repeat (8) @(negedge clk);
    ext_low = 1'b0;
    repeat (400) @(negedge clk);
    peek(2'd3, s);
    chk(s[2] == 1'b0, "R10 glitch not a start", s[2], 0);
    send_frame(8'h5A, 1'b0, 1'b0, 1'b0);
    reg_rd(2'd2, v);
    chk(v == 8'h5A, "R10 frame after glitch", v, 8'h5A);
    reg_wr(2'd3, 8'h20);
  endtask

  task automatic t_disable();
    logic [7:0] s;
    int lat;
    set_div(1);
    reg_wr(2'd0, 8'h00);
    send_frame(8'hC3, 1'b0, 1'b0, 1'b0);
    peek(2'd3, s);
    chk(s[2] == 1'b0 && s[5] == 1'b0, "R11 rx off ignores frame", s, 0);
    reg_wr(2'd0, 8'h01);
    reg_wr(2'd2, 8'h00);
    wait_fall(lat);
    repeat (3 * bitc) @(negedge clk);
    chk(line == 1'b0, "R11 frame low before abort", line, 0);
    reg_wr(2'd0, 8'h00);
    @(negedge clk);
    peek(2'd3, s);
    chk(line == 1'b1, "R11 abort releases line", line, 1);
    chk(s[1] == 1'b1, "R11 abort empties register", s[1], 1);
    reg_wr(2'd3, 8'h30);
  endtask

  task automatic t_loop();
    logic [7:0] s, v;
    int lat;
    set_div(1);
    reg_wr(2'd0, 8'h03);
    reg_wr(2'd2, 8'h3C);
    wait_fall(lat);
    repeat (11 * bitc + 80) @(negedge clk);
    peek(2'd3, s);
    chk(s[2] == 1'b1 && s[3] == 1'b0, "R12 own frame received clean", s[3:2], 1);
    reg_rd(2'd2, v);
    chk(v == 8'h3C, "R12 loopback data", v, 8'h3C);
    reg_wr(2'd0, 8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_tx(8'hB3, 1'b0, 1'b0, 1);
    t_irq_clear();
    t_tx(8'h81, 1'b1, 1'b1, 3);
    t_tx(8'h81, 1'b0, 1'b0, 1);
    t_rx(8'h6D, 1'b0, 1'b0);
    t_rx(8'h6D, 1'b0, 1'b1);
    t_rx(8'h29, 1'b1, 1'b1);
    t_glitch();
    t_disable();
    t_loop();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule